// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block turns one-cycle command strobes into correctly timed SCL and SDA waveforms for an I2C master. It produces the start condition, the repeated start, the stop condition with its bus-free interval, and single data-bit slots. Each phase lasts a fixed number of periods of a timing tick. The tick is supplied by an external divider of the base clock. Byte framing, acknowledge handling, arbitration and clock stretching belong to the layer above.

Phase lengths come from two settings. A speed select chooses standard or fast mode, and a slow-down field stretches the bit period by 0, 10, 20 or 30 percent. The SDA hold time after SCL falls does not change with the slow-down setting. The other phases grow with it. Both lines are driven open-drain: an enable output pulls a line low, and releasing the enable lets the line float high. During a bit slot the generator reads the SDA line at the end of the SCL high phase and reports the value with a one-cycle pulse.

Top module: `i2c_bit_timer`

## Requirements
- R1: While reset is asserted and after it is released, both pull-down enables, busy and the done pulse are 0.
- R2: In standard mode with no slow-down, a bit slot has 18 ticks of setup (SCL low, SDA showing the bit), then 18 ticks of SCL high, then 4 ticks of hold (SCL low). That is a 40-tick period with 22 ticks low.
- R3: In standard mode, slow-down codes 1, 2 and 3 give an SCL high of 20, 22 and 24 ticks and an SCL low of 24, 26 and 28 ticks. Setup always equals the high time, and hold stays at 4 ticks.
- R4: In fast mode (speed select 1), slow-down codes 0 to 3 give SCL high of 4, 4, 5 and 5 ticks and data setup of 4, 5, 5 and 6 ticks, with hold fixed at 2 ticks. The resulting periods are 10, 11, 12 and 13 ticks.
- R5: A start pulls SDA low while SCL stays released for the high time. It then pulls SCL low for the hold time and leaves both lines held low.
- R6: A repeated start runs four phases. First SDA is released with SCL low for the setup time. Next SCL is released for the low time. SDA is then pulled low with SCL high for the high time. Finally SCL is pulled low for the hold time.
- R7: A stop runs three phases. First SDA is pulled low with SCL low for the setup time. Next SCL is released for the high time. SDA is then released, and busy stays set for a bus-free interval equal to the low time. The command ends with both lines released.
- R8: An enable output of 1 means the line is pulled low, and 0 means the line is released. Between commands, the lines keep the levels that the last phase left.
- R9: Busy rises in the cycle after a command is accepted and falls once the last phase has ended. Any strobe seen at an edge while busy is 1 is ignored, including the edge that ends the command.
- R10: The speed and slow-down inputs are captured when a command is accepted. Changing them during the command does not alter any of its phase lengths.
- R11: For a bit slot, a single-cycle done pulse appears together with the SCL fall that ends the high phase. At the same time the received-bit output shows SDA as sampled at that edge.
- R12: A phase advances only at edges where the tick enable is 1. A tick present in the cycle in which a command is accepted is not counted toward the first phase.
- R13: When several strobes arrive together at an idle edge, exactly one is accepted, in the priority order start, restart, stop, bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timing tick, one clock wide per tick |
| fast_mode | input | 1 | 0 selects standard timing, 1 selects fast timing |
| slow_sel | input | 2 | Slow-down code: 0, 10, 20 or 30 percent |
| cmd_start | input | 1 | Start strobe |
| cmd_restart | input | 1 | Repeated-start strobe |
| cmd_stop | input | 1 | Stop strobe |
| cmd_bit | input | 1 | Data-bit strobe |
| tx_bit | input | 1 | Bit value driven in a bit slot, taken with the strobe |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | SCL pull-down enable |
| sda_oe | output | 1 | SDA pull-down enable |
| busy | output | 1 | Command in progress |
| bit_done | output | 1 | One-cycle pulse at the end of a bit's high phase |
| rx_bit | output | 1 | SDA value sampled with the latest done pulse |

## Verification
Two things can meet at one clock edge. A new command strobe can arrive at the edge that retires the final phase of the current command. Several strobes can also arrive together at an idle edge. The bench drives a stop strobe into the exact last busy cycle of a bit slot, with the cycle located from the expected phase lengths. It then confirms that busy stays low one cycle later and that SCL remains held. It also drives start, restart, stop and bit strobes in combination and compares the tick-weighted phase list that results with the phase list of the command that should win.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  localparam int unsigned BT_TW = 6;

  typedef struct packed {
    logic [BT_TW-1:0] high;
    logic [BT_TW-1:0] low;
    logic [BT_TW-1:0] setup;
    logic [BT_TW-1:0] hold;
  } bt_times_t;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_START,
    CMD_RESTART,
    CMD_STOP,
    CMD_BIT
  } bt_cmd_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ST_HOLD,
    PH_ST_LOW,
    PH_BIT_SU,
    PH_BIT_HI,
    PH_BIT_HD,
    PH_RS_SU,
    PH_RS_HI,
    PH_RS_HD,
    PH_RS_LO,
    PH_SP_SU,
    PH_SP_HI,
    PH_SP_BUF
  } bt_phase_e;

endpackage

// File: rtl/i2c_bt_timing.sv
module i2c_bt_timing
  import i2c_bt_pkg::*;
#(
  parameter int unsigned STD_HIGH  = 18,
  parameter int unsigned STD_LOW   = 22,
  parameter int unsigned STD_HOLD  = 4,
  parameter int unsigned STD_STEP  = 2,
  parameter int unsigned FAST_HIGH = 4,
  parameter int unsigned FAST_LOW  = 6,
  parameter int unsigned FAST_HOLD = 2
) (
  input  logic       fast,
  input  logic [1:0] slow,
  output bt_times_t  times
);

  localparam int unsigned TW = BT_TW;

  logic [TW-1:0] slow_w;
  logic [TW-1:0] high_w;
  logic [TW-1:0] low_w;
  logic [TW-1:0] hold_w;

  assign slow_w = TW'(slow);

  // Standard mode stretches high and low by equal steps. Fast mode adds
  // one tick to low on codes 1 and 3 and one tick to high on code 2, so
  // the period grows by exactly one tick per code.
  always_comb begin
    if (fast) begin
      high_w = TW'(FAST_HIGH) + (slow_w >> 1);
      low_w  = TW'(FAST_LOW) + ((slow_w + TW'(1)) >> 1);
      hold_w = TW'(FAST_HOLD);
    end else begin
      high_w = TW'(STD_HIGH) + TW'(STD_STEP) * slow_w;
      low_w  = TW'(STD_LOW) + TW'(STD_STEP) * slow_w;
      hold_w = TW'(STD_HOLD);
    end
  end

  // The SCL low time is split into hold followed by setup.
  assign times.high  = high_w;
  assign times.low   = low_w;
  assign times.hold  = hold_w;
  assign times.setup = low_w - hold_w;

endmodule

// File: rtl/i2c_bt_count.sv
module i2c_bt_count #(
  parameter int unsigned TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  input  logic          tick,
  output logic          last
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  assign last = tick && (cnt_q == TW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = len;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3: every loaded phase length is non-zero, otherwise the phase would never end
  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (len != '0));

endmodule

// File: rtl/i2c_bt_seq.sv
module i2c_bt_seq
  import i2c_bt_pkg::*;
#(
  parameter int unsigned TW = BT_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_restart,
  input  logic          cmd_stop,
  input  logic          cmd_bit,
  input  logic          tx_bit,
  input  logic          fast_mode,
  input  logic [1:0]    slow_sel,
  input  logic          sda_in,
  input  bt_times_t     times,
  input  logic          last,
  output logic          sel_fast,
  output logic [1:0]    sel_slow,
  output logic          load,
  output logic [TW-1:0] len,
  output logic          scl_lvl,
  output logic          sda_lvl,
  output logic          busy,
  output logic          bit_done,
  output logic          rx_bit
);

  bt_phase_e  phase_q, phase_d;
  bt_cmd_e    pick;
  logic       accept;
  logic       bit_q, bit_use;
  logic       fast_q;
  logic [1:0] slow_q;
  logic       scl_q, scl_d, sda_q, sda_d;
  logic       done_q, done_d;
  logic       rx_q, rx_d;

  function automatic logic [1:0] levels(input bt_phase_e ph, input logic b);
    case (ph)
      PH_ST_HOLD: levels = 2'b10;
      PH_ST_LOW:  levels = 2'b00;
      PH_BIT_SU:  levels = {1'b0, b};
      PH_BIT_HI:  levels = {1'b1, b};
      PH_BIT_HD:  levels = {1'b0, b};
      PH_RS_SU:   levels = 2'b01;
      PH_RS_HI:   levels = 2'b11;
      PH_RS_HD:   levels = 2'b10;
      PH_RS_LO:   levels = 2'b00;
      PH_SP_SU:   levels = 2'b00;
      PH_SP_HI:   levels = 2'b10;
      PH_SP_BUF:  levels = 2'b11;
      default:    levels = 2'b11;
    endcase
  endfunction

  // Command choice by fixed priority
  always_comb begin
    if (cmd_start)        pick = CMD_START;
    else if (cmd_restart) pick = CMD_RESTART;
    else if (cmd_stop)    pick = CMD_STOP;
    else if (cmd_bit)     pick = CMD_BIT;
    else                  pick = CMD_NONE;
  end

  assign accept   = (phase_q == PH_IDLE) && (pick != CMD_NONE);
  assign sel_fast = accept ? fast_mode : fast_q;
  assign sel_slow = accept ? slow_sel : slow_q;
  assign bit_use  = accept ? tx_bit : bit_q;

  // Phase sequencing
  always_comb begin
    phase_d = phase_q;
    if (accept) begin
      case (pick)
        CMD_START:   phase_d = PH_ST_HOLD;
        CMD_RESTART: phase_d = PH_RS_SU;
        CMD_STOP:    phase_d = PH_SP_SU;
        default:     phase_d = PH_BIT_SU;
      endcase
    end else if (last) begin
      case (phase_q)
        PH_ST_HOLD: phase_d = PH_ST_LOW;
        PH_BIT_SU:  phase_d = PH_BIT_HI;
        PH_BIT_HI:  phase_d = PH_BIT_HD;
        PH_RS_SU:   phase_d = PH_RS_HI;
        PH_RS_HI:   phase_d = PH_RS_HD;
        PH_RS_HD:   phase_d = PH_RS_LO;
        PH_SP_SU:   phase_d = PH_SP_HI;
        PH_SP_HI:   phase_d = PH_SP_BUF;
        default:    phase_d = PH_IDLE;
      endcase
    end
  end

  assign load = (phase_d != phase_q) && (phase_d != PH_IDLE);

  always_comb begin
    case (phase_d)
      PH_ST_HOLD, PH_BIT_HI, PH_RS_HD, PH_SP_HI: len = times.high;
      PH_RS_HI, PH_SP_BUF:                       len = times.low;
      PH_BIT_SU, PH_RS_SU, PH_SP_SU:             len = times.setup;
      PH_ST_LOW, PH_BIT_HD, PH_RS_LO:            len = times.hold;
      default:                                   len = '0;
    endcase
  end

  // Line levels change only on phase entry; entering idle keeps them
  always_comb begin
    {scl_d, sda_d} = {scl_q, sda_q};
    if (load) begin
      {scl_d, sda_d} = levels(phase_d, bit_use);
    end
  end

  assign done_d = last && (phase_q == PH_BIT_HI);
  assign rx_d   = done_d ? sda_in : rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      done_q  <= 1'b0;
      rx_q    <= 1'b0;
      bit_q   <= 1'b0;
      fast_q  <= 1'b0;
      slow_q  <= 2'b00;
    end else begin
      phase_q <= phase_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      done_q  <= done_d;
      rx_q    <= rx_d;
      if (accept) begin
        bit_q  <= tx_bit;
        fast_q <= fast_mode;
        slow_q <= slow_sel;
      end
    end
  end

  assign scl_lvl  = scl_q;
  assign sda_lvl  = sda_q;
  assign busy     = (phase_q != PH_IDLE);
  assign bit_done = done_q;
  assign rx_bit   = rx_q;

  // R9: while busy, a strobe cannot move the phase unless the counter ends it
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (phase_q == $past(phase_q)));

  // R10: the captured settings hold still for the whole command
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(fast_q) && $stable(slow_q)));

  // R11: the done pulse is one cycle wide
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R11: the done pulse coincides with the fall of SCL
  p_done_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!scl_q && $past(scl_q)));

  // R5: SDA moves with SCL high only for start, repeated start or stop
  p_sda_under_scl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q) && (sda_q != $past(sda_q))) |->
      (phase_q inside {PH_ST_HOLD, PH_RS_HD, PH_SP_BUF}));

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       fast_mode,
  input  logic [1:0] slow_sel,
  input  logic       cmd_start,
  input  logic       cmd_restart,
  input  logic       cmd_stop,
  input  logic       cmd_bit,
  input  logic       tx_bit,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       bit_done,
  output logic       rx_bit
);

  localparam int unsigned TW = BT_TW;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          sel_fast;
  logic [1:0]    sel_slow;
  bt_times_t     times;
  logic          load;
  logic [TW-1:0] len;
  logic          last;
  logic          scl_lvl;
  logic          sda_lvl;

  // Reset asserts at once and leaves synchronously
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  i2c_bt_timing u_timing (
    .fast  (sel_fast),
    .slow  (sel_slow),
    .times (times)
  );

  i2c_bt_count #(.TW(TW)) u_count (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (load),
    .len   (len),
    .tick  (tick_en),
    .last  (last)
  );

  i2c_bt_seq #(.TW(TW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cmd_start   (cmd_start),
    .cmd_restart (cmd_restart),
    .cmd_stop    (cmd_stop),
    .cmd_bit     (cmd_bit),
    .tx_bit      (tx_bit),
    .fast_mode   (fast_mode),
    .slow_sel    (slow_sel),
    .sda_in      (sda_in),
    .times       (times),
    .last        (last),
    .sel_fast    (sel_fast),
    .sel_slow    (sel_slow),
    .load        (load),
    .len         (len),
    .scl_lvl     (scl_lvl),
    .sda_lvl     (sda_lvl),
    .busy        (busy),
    .bit_done    (bit_done),
    .rx_bit      (rx_bit)
  );

  assign scl_oe = ~scl_lvl;
  assign sda_oe = ~sda_lvl;

endmodule

// File: tb/i2c_bit_timer_bench.sv
module i2c_bit_timer_bench;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       fast_mode;
  logic [1:0] slow_sel;
  logic       cmd_start, cmd_restart, cmd_stop, cmd_bit;
  logic       tx_bit;
  logic       slave_pull;
  logic       sda_in;
  logic       scl_oe, sda_oe, busy, bit_done, rx_bit;

  int n_checks;
  int n_fails;

  int   seg_n;
  logic seg_scl [8];
  logic seg_sda [8];
  int   seg_len [8];
  int   exp_n;
  logic exp_scl [8];
  logic exp_sda [8];
  int   exp_len [8];

  int         done_cnt, done_at;
  logic       rx_seen;
  int         div;
  int         poke_at;
  logic [3:0] poke_mask;
  int         chg_at;
  logic       chg_fast;
  logic [1:0] chg_slow;

  localparam int K_START   = 0;
  localparam int K_RESTART = 1;
  localparam int K_STOP    = 2;
  localparam int K_BIT     = 3;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign sda_in = sda_oe ? 1'b0 : ~slave_pull;

  i2c_bit_timer u_i2c_bit_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .fast_mode   (fast_mode),
    .slow_sel    (slow_sel),
    .cmd_start   (cmd_start),
    .cmd_restart (cmd_restart),
    .cmd_stop    (cmd_stop),
    .cmd_bit     (cmd_bit),
    .tx_bit      (tx_bit),
    .sda_in      (sda_in),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .busy        (busy),
    .bit_done    (bit_done),
    .rx_bit      (rx_bit)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic get_t(input logic f, input logic [1:0] s,
                       output int hi, output int lo, output int su, output int hd);
    if (!f) begin
      case (s)
        2'd0: begin hi = 18; lo = 22; end
        2'd1: begin hi = 20; lo = 24; end
        2'd2: begin hi = 22; lo = 26; end
        default: begin hi = 24; lo = 28; end
      endcase
      su = hi;
      hd = 4;
    end else begin
      case (s)
        2'd0: begin hi = 4; lo = 6; su = 4; end
        2'd1: begin hi = 4; lo = 7; su = 5; end
        2'd2: begin hi = 5; lo = 7; su = 5; end
        default: begin hi = 5; lo = 8; su = 6; end
      endcase
      hd = 2;
    end
  endtask

  task automatic add_exp(input logic c, input logic d, input int l);
    exp_scl[exp_n] = c;
    exp_sda[exp_n] = d;
    exp_len[exp_n] = l;
    exp_n++;
  endtask

  task automatic build_exp(input int kind, input logic b, input logic f, input logic [1:0] s);
    int hi, lo, su, hd;
    get_t(f, s, hi, lo, su, hd);
    exp_n = 0;
    case (kind)
      K_START:   begin add_exp(1, 0, hi); add_exp(0, 0, hd); end
      K_RESTART: begin add_exp(0, 1, su); add_exp(1, 1, lo); add_exp(1, 0, hi); add_exp(0, 0, hd); end
      K_STOP:    begin add_exp(0, 0, su); add_exp(1, 0, hi); add_exp(1, 1, lo); end
      default:   begin add_exp(0, b, su); add_exp(1, b, hi); add_exp(0, b, hd); end
    endcase
  endtask

  task automatic set_cmds(input logic [3:0] m);
    cmd_start   = m[0];
    cmd_restart = m[1];
    cmd_stop    = m[2];
    cmd_bit     = m[3];
  endtask

  // Issues a strobe set, then records tick-weighted line segments while busy
  task automatic run(input logic [3:0] mask, input logic b);
    int   idx;
    int   tc;
    logic tk, c, d;
    seg_n = 0; done_cnt = 0; done_at = -1; rx_seen = 1'b0;
    @(negedge clk);
    set_cmds(mask);
    tx_bit  = b;
    tick_en = 1'b1;
    tc  = 1;
    idx = 0;
    forever begin
      @(negedge clk);
      set_cmds(4'b0000);
      if (!busy || idx > 4000) break;
      tk = ((tc % div) == 0);
      tc++;
      tick_en = tk;
      c = ~scl_oe;
      d = ~sda_oe;
      if (seg_n > 0 && seg_scl[seg_n-1] == c && seg_sda[seg_n-1] == d) begin
        seg_len[seg_n-1] += int'(tk);
      end else if (seg_n < 8) begin
        seg_scl[seg_n] = c;
        seg_sda[seg_n] = d;
        seg_len[seg_n] = int'(tk);
        seg_n++;
      end
      if (bit_done) begin
        done_cnt++;
        done_at = idx;
        rx_seen = rx_bit;
      end
      if (idx == poke_at) set_cmds(poke_mask);
      if (idx == chg_at) begin
        fast_mode = chg_fast;
        slow_sel  = chg_slow;
      end
      idx++;
    end
    chk("R9", "busy window ends", int'(idx > 4000), 0);
    tick_en = 1'b1;
  endtask

  task automatic cmp(input string req);
    chk(req, "phase count", seg_n, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      if (i < seg_n) begin
        chk(req, $sformatf("phase %0d levels", i),
            int'({seg_scl[i], seg_sda[i]}), int'({exp_scl[i], exp_sda[i]}));
        chk(req, $sformatf("phase %0d ticks", i), seg_len[i], exp_len[i]);
      end
    end
  endtask

  task automatic do_cmd(input logic [3:0] mask, input int kind, input logic b, input string req);
    build_exp(kind, b, fast_mode, slow_sel);
    run(mask, b);
    cmp(req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "scl_oe in reset", int'(scl_oe), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "scl_oe after reset", int'(scl_oe), 0);
    chk("R1", "sda_oe after reset", int'(sda_oe), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "bit_done after reset", int'(bit_done), 0);
  endtask

  task automatic t_std_frame;
    fast_mode = 1'b0; slow_sel = 2'd0; div = 1;
    do_cmd(4'b0001, K_START, 1'b0, "R5");
    chk("R8", "scl held low after start", int'(scl_oe), 1);
    chk("R8", "sda held low after start", int'(sda_oe), 1);
    slave_pull = 1'b1;
    do_cmd(4'b1000, K_BIT, 1'b1, "R2");
    chk("R11", "done pulses", done_cnt, 1);
    chk("R11", "done position", done_at, 36);
    chk("R11", "rx with line pulled", int'(rx_seen), 0);
    slave_pull = 1'b0;
    do_cmd(4'b1000, K_BIT, 1'b1, "R2");
    chk("R11", "rx with line free", int'(rx_seen), 1);
    chk("R8", "sda released after bit 1", int'(sda_oe), 0);
    do_cmd(4'b1000, K_BIT, 1'b0, "R2");
    chk("R11", "rx of own low", int'(rx_seen), 0);
    do_cmd(4'b0100, K_STOP, 1'b0, "R7");
    chk("R7", "scl released after stop", int'(scl_oe), 0);
    chk("R7", "sda released after stop", int'(sda_oe), 0);
    chk("R11", "no done on stop", done_cnt, 0);
  endtask

  task automatic t_std_slow;
    fast_mode = 1'b0; div = 1;
    slow_sel = 2'd1;
    do_cmd(4'b0001, K_START, 1'b0, "R3");
    for (int s = 1; s < 4; s++) begin
      slow_sel = 2'(s);
      do_cmd(4'b1000, K_BIT, s[0], "R3");
    end
    do_cmd(4'b0100, K_STOP, 1'b0, "R3");
  endtask

  task automatic t_fast;
    fast_mode = 1'b1; slow_sel = 2'd0; div = 1;
    do_cmd(4'b0001, K_START, 1'b0, "R4");
    for (int s = 0; s < 4; s++) begin
      slow_sel = 2'(s);
      do_cmd(4'b1000, K_BIT, ~s[0], "R4");
    end
    slow_sel = 2'd2;
    do_cmd(4'b0010, K_RESTART, 1'b0, "R6");
    chk("R6", "lines held low after restart", int'({scl_oe, sda_oe}), 3);
    do_cmd(4'b1000, K_BIT, 1'b1, "R4");
    slow_sel = 2'd1;
    do_cmd(4'b0100, K_STOP, 1'b0, "R7");
  endtask

  task automatic t_tick_div;
    fast_mode = 1'b0; slow_sel = 2'd1; div = 3;
    do_cmd(4'b0001, K_START, 1'b0, "R12");
    do_cmd(4'b1000, K_BIT, 1'b1, "R12");
    do_cmd(4'b0100, K_STOP, 1'b0, "R12");
    div = 1;
  endtask

  task automatic t_busy;
    int total;
    fast_mode = 1'b1; slow_sel = 2'd3; div = 1;
    do_cmd(4'b0001, K_START, 1'b0, "R9");
    poke_at = 5; poke_mask = 4'b0001;
    do_cmd(4'b1000, K_BIT, 1'b1, "R9");
    build_exp(K_BIT, 1'b0, fast_mode, slow_sel);
    total = 0;
    for (int i = 0; i < exp_n; i++) total += exp_len[i];
    poke_at = total - 1; poke_mask = 4'b0100;
    run(4'b1000, 1'b0);
    cmp("R9");
    poke_at = -1;
    @(negedge clk);
    chk("R9", "strobe at final busy edge ignored", int'(busy), 0);
    chk("R9", "scl still held after ignored stop", int'(scl_oe), 1);
    do_cmd(4'b0100, K_STOP, 1'b0, "R9");
  endtask

  task automatic t_cfg;
    fast_mode = 1'b0; slow_sel = 2'd0; div = 1;
    do_cmd(4'b0001, K_START, 1'b0, "R10");
    chg_at = 3; chg_fast = 1'b1; chg_slow = 2'd3;
    do_cmd(4'b1000, K_BIT, 1'b1, "R10");
    chg_at = -1;
    fast_mode = 1'b0; slow_sel = 2'd0;
    do_cmd(4'b0100, K_STOP, 1'b0, "R10");
  endtask

  task automatic t_priority;
    fast_mode = 1'b1; slow_sel = 2'd0; div = 1;
    do_cmd(4'b0101, K_START, 1'b0, "R13");
    do_cmd(4'b1110, K_RESTART, 1'b0, "R13");
    do_cmd(4'b1100, K_STOP, 1'b0, "R13");
    chk("R13", "lines released after stop won", int'({scl_oe, sda_oe}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    n_checks = 0; n_fails = 0;
    rst_n = 1'b0; tick_en = 1'b1; fast_mode = 1'b0; slow_sel = 2'd0;
    cmd_start = 1'b0; cmd_restart = 1'b0; cmd_stop = 1'b0; cmd_bit = 1'b0;
    tx_bit = 1'b0; slave_pull = 1'b0; div = 1;
    poke_at = -1; poke_mask = 4'b0000; chg_at = -1; chg_fast = 1'b0; chg_slow = 2'd0;
    t_reset;
    t_std_frame;
    t_std_slow;
    t_fast;
    t_tick_div;
    t_busy;
    t_cfg;
    t_priority;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule